// File: doc/BRIEF.md
# Parallel EEPROM Write and Status Controller

This block is a clocked, cycle-level model of the control side of a byte-wide electrically erasable memory. A host drives active-low chip-select, write-strobe and read-strobe lines, a 13-bit address and an 8-bit data bus. The bus is split here into an input, an output and an output-enable. All strobes are sampled on the system clock and are assumed to be synchronous to it. A write access opens when chip-select and write-strobe are both low with read-strobe high. The address is taken when the access opens and the data when it closes.

Accepted bytes gather in a 64-byte page buffer. The page closes when the host stops writing for a set number of clocks. A self-timed internal write then commits every loaded byte of the page at once. While that write runs, reads return status instead of memory contents: bit 7 holds the inverse of the last loaded bit 7, and bit 6 flips from one read to the next. A command-sequence protection latch can lock the block so that only writes that follow an unlock-for-one-page command are accepted. A longer command sequence removes the lock.

The storage is an internal register array of 2^ARR_W bytes. Addresses alias onto it by their low ARR_W bits. The page window length and the internal write length are parameters counted in clocks.

Top module: `eep_ctl`

## Requirements
- R1: After reset every stored byte reads 0x00. `dout_oe` is high only while `ce_n` and `oe_n` are low and `we_n` is high. On that read, `dout` carries the byte stored at the address.
- R2: A strobe counts as a write only while `ce_n` and `we_n` are low and `oe_n` is high. Pulling `ce_n` and `we_n` low with `oe_n` also low stores nothing.
- R3: The address of a write is the one present in the first clock of the access. The data is the value on `din` in the last clock before the access ends. Address changes later in the access have no effect.
- R4: Up to 64 bytes that share address bits [12:6] are loaded and then committed by one internal write. All of them read back correctly once that write is over.
- R5: While a page is loading, a byte whose address bits [12:6] differ from those of the page's first byte is dropped.
- R6: The internal write starts once LOAD_WIN clocks pass with no write access. It lasts WRITE_CYC clocks, and every byte written during it is dropped.
- R7: During the internal write, bit 7 of a read is the inverse of bit 7 of the last loaded byte. After the write, reads return the stored data.
- R8: During the internal write, bit 6 takes opposite values on two successive reads. Once the write is over, repeated reads give a steady bit 6.
- R9: The writes 0xAA to 0x1555, 0x55 to 0x0AAA, then 0xA0 to 0x1555 set protection and allow one page load. While protection is set, any write not preceded by that sequence within the page window is dropped.
- R10: The six writes 0xAA to 0x1555, 0x55 to 0x0AAA, 0x80 to 0x1555, 0xAA to 0x1555, 0x55 to 0x0AAA, then 0x20 to 0x1555 clear protection. After that, plain writes are stored.
- R11: A read access placed between steps of a command sequence aborts it. The protection state stays as it was.
- R12: Bytes taken up as steps of a command sequence are never stored in the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read strobe, active low |
| addr | input | 13 | Byte address |
| din | input | 8 | Data from the host |
| dout | output | 8 | Read data or write-in-progress status |
| dout_oe | output | 1 | Drive enable for the data bus; low means high impedance |

## Verification
A wrong page tag or a stale byte mask does not show until the internal write finishes. It then appears as a missing or misplaced byte on the next read of that page, so the bench reads back every byte of a full page. A broken window counter or write timer shows as status words where data belongs, or data where status belongs, on the first read after the window should have closed. A protection or command-step error shows only on the write after the sequence: a byte that should have been stored reads back 0x00, or a byte that should have been dropped reads back its data, once one write time has passed.

// File: rtl/eep_pkg.sv
// Shared constants and types for the parallel EEPROM controller.
// Assumes command addresses are 13 bits wide; narrower buses compare truncated values.
package eep_pkg;

    localparam int CMD_AW = 13;
    localparam logic [CMD_AW-1:0] CMD_ADDR_A = 13'h1555;
    localparam logic [CMD_AW-1:0] CMD_ADDR_B = 13'h0AAA;

    localparam logic [7:0] CMD_KEY1    = 8'hAA;
    localparam logic [7:0] CMD_KEY2    = 8'h55;
    localparam logic [7:0] CMD_ARM     = 8'hA0;
    localparam logic [7:0] CMD_UNLOCK1 = 8'h80;
    localparam logic [7:0] CMD_UNLOCK2 = 8'h20;

    // Command sequence progress; the two sequences share their first two steps.
    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_K1    = 3'd1,
        SQ_K2    = 3'd2,
        SQ_UL1   = 3'd3,
        SQ_UL_K1 = 3'd4,
        SQ_UL_K2 = 3'd5
    } seq_t;

endpackage

// File: rtl/eep_strobe.sv
// Strobe sampler: decodes write and read accesses from the sampled strobe
// levels, latches the address when a write access opens and holds the last
// data value seen before it closes.
// Assumes strobes are synchronous to clk and held for at least one clock.
module eep_strobe #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              wr_end,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_start,
    output logic              rd_end
);

    logic wr_sel;
    logic rd_sel;
    logic wr_q;
    logic rd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    // Access decode from the current strobe levels.
    always_comb begin
        wr_sel = !ce_n && !we_n && oe_n;
        rd_sel = !ce_n && !oe_n && we_n;
    end

    // Edge history plus address and data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q   <= 1'b0;
            rd_q   <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            wr_q <= wr_sel;
            rd_q <= rd_sel;
            if (wr_sel && !wr_q) begin
                addr_q <= addr;
            end
            if (wr_sel) begin
                data_q <= din;
            end
        end
    end

    // Access boundary events and captured values.
    always_comb begin
        wr_end   = wr_q && !wr_sel;
        rd_start = rd_sel && !rd_q;
        rd_end   = rd_q && !rd_sel;
        wr_addr  = addr_q;
        wr_data  = data_q;
    end

    AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_q && wr_sel) |=> $stable(addr_q)); // R3

endmodule

// File: rtl/eep_guard.sv
// Protection guard: tracks the arm and unlock command sequences, holds the
// protection latch and decides whether a finished write byte is page data.
// Assumes a read access between command steps aborts the sequence.
module eep_guard #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_end,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_start,
    input  logic              busy,
    input  logic              win_expire,
    output logic              take
);
    import eep_pkg::*;

    seq_t step;
    seq_t step_nx;
    logic prot;
    logic armed;
    logic consumed;
    logic set_p;
    logic clr_p;
    logic ev;
    logic at_a, at_b;
    logic hit_k1, hit_k2, hit_arm, hit_ul1, hit_ul2;

    // Command step matching on the finished byte.
    always_comb begin
        at_a    = (wr_addr == ADDR_W'(CMD_ADDR_A));
        at_b    = (wr_addr == ADDR_W'(CMD_ADDR_B));
        hit_k1  = at_a && (wr_data == DATA_W'(CMD_KEY1));
        hit_k2  = at_b && (wr_data == DATA_W'(CMD_KEY2));
        hit_arm = at_a && (wr_data == DATA_W'(CMD_ARM));
        hit_ul1 = at_a && (wr_data == DATA_W'(CMD_UNLOCK1));
        hit_ul2 = at_a && (wr_data == DATA_W'(CMD_UNLOCK2));
        ev      = wr_end && !busy;
    end

    // Next sequence step and latch actions.
    always_comb begin
        step_nx  = SQ_IDLE;
        consumed = 1'b0;
        set_p    = 1'b0;
        clr_p    = 1'b0;
        case (step)
            SQ_IDLE: if (hit_k1) begin
                step_nx = SQ_K1; consumed = 1'b1;
            end
            SQ_K1: if (hit_k2) begin
                step_nx = SQ_K2; consumed = 1'b1;
            end
            SQ_K2: if (hit_arm) begin
                set_p = 1'b1; consumed = 1'b1;
            end else if (hit_ul1) begin
                step_nx = SQ_UL1; consumed = 1'b1;
            end
            SQ_UL1: if (hit_k1) begin
                step_nx = SQ_UL_K1; consumed = 1'b1;
            end
            SQ_UL_K1: if (hit_k2) begin
                step_nx = SQ_UL_K2; consumed = 1'b1;
            end
            SQ_UL_K2: if (hit_ul2) begin
                clr_p = 1'b1; consumed = 1'b1;
            end
            default: step_nx = SQ_IDLE;
        endcase
    end

    // Sequence state, protection latch and one-page arm flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step  <= SQ_IDLE;
            prot  <= 1'b0;
            armed <= 1'b0;
        end else begin
            if (ev) begin
                step <= step_nx;
                if (set_p) begin
                    prot  <= 1'b1;
                    armed <= 1'b1;
                end
                if (clr_p) begin
                    prot  <= 1'b0;
                    armed <= 1'b0;
                end
            end else if (rd_start) begin
                step <= SQ_IDLE;
            end
            if (win_expire) begin
                armed <= 1'b0;
            end
        end
    end

    // A byte is page data when not part of a command and writes are allowed.
    assign take = ev && !consumed && (!prot || armed);

    AST_SET_AFTER_KEYS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot) |-> ($past(step) == SQ_K2)); // R9
    AST_CLEAR_AFTER_SIX: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot) |-> ($past(step) == SQ_UL_K2)); // R10
    AST_READ_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && !wr_end) |=> (step == SQ_IDLE)); // R11

endmodule

// File: rtl/eep_page.sv
// Page loader: collects accepted bytes of one page with a per-byte mask,
// runs the idle window counter and requests the internal write when the
// window closes with a page loaded.
// Assumes the mask is cleared only by the commit-done pulse.
module eep_page #(
    parameter int ADDR_W   = 13,
    parameter int DATA_W   = 8,
    parameter int PAGE_W   = 6,
    parameter int ARR_W    = 11,
    parameter int LOAD_WIN = 100,
    localparam int PAGE_N  = 1 << PAGE_W,
    localparam int TAG_W   = ADDR_W - PAGE_W,
    localparam int ROW_W   = ARR_W - PAGE_W,
    localparam int CNT_W   = $clog2(LOAD_WIN + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           take,
    input  logic                           wr_end,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic                           busy,
    input  logic                           done,
    output logic [PAGE_N-1:0][DATA_W-1:0]  pg_data,
    output logic [PAGE_N-1:0]              pg_mask,
    output logic [ROW_W-1:0]               pg_row,
    output logic [DATA_W-1:0]              last_data,
    output logic                           win_expire,
    output logic                           start
);

    logic             active;
    logic [TAG_W-1:0] tag;
    logic [CNT_W-1:0] idle_cnt;
    logic             tag_ok;
    logic             store;
    logic [PAGE_W-1:0] idx;

    // Byte acceptance against the open page.
    always_comb begin
        idx    = wr_addr[PAGE_W-1:0];
        tag_ok = !active || (wr_addr[ADDR_W-1:PAGE_W] == tag);
        store  = take && tag_ok;
        pg_row = tag[ROW_W-1:0];
    end

    // Page state: open flag, tag, mask and last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            tag       <= '0;
            pg_mask   <= '0;
            last_data <= '0;
        end else if (done) begin
            active  <= 1'b0;
            pg_mask <= '0;
        end else if (store) begin
            if (!active) begin
                active <= 1'b1;
                tag    <= wr_addr[ADDR_W-1:PAGE_W];
            end
            pg_mask[idx] <= 1'b1;
            last_data    <= wr_data;
        end
    end

    // Page byte storage, one register per slot.
    for (genvar g = 0; g < PAGE_N; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pg_data[g] <= '0;
            end else if (store && (idx == PAGE_W'(g))) begin
                pg_data[g] <= wr_data;
            end
        end
    end

    // Clocks since the last write access, saturating at the window length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= CNT_W'(LOAD_WIN);
        end else if (wr_end) begin
            idle_cnt <= '0;
        end else if (idle_cnt != CNT_W'(LOAD_WIN)) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    // Window close and internal write request.
    always_comb begin
        win_expire = !wr_end && (idle_cnt == CNT_W'(LOAD_WIN - 1));
        start      = win_expire && active && !busy;
    end

    AST_NO_LOAD_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        store |-> !busy); // R6
    AST_PAGE_EMPTY_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (pg_mask == '0) && !active); // R4

endmodule

// File: rtl/eep_array.sv
// Storage and timer: runs the self-timed internal write, commits masked page
// bytes into the register array at its end, and forms read data or status.
// Assumes start is raised only while idle.
module eep_array #(
    parameter int DATA_W    = 8,
    parameter int PAGE_W    = 6,
    parameter int ARR_W     = 11,
    parameter int WRITE_CYC = 500000,
    localparam int PAGE_N   = 1 << PAGE_W,
    localparam int ARR_N    = 1 << ARR_W,
    localparam int ROW_W    = ARR_W - PAGE_W,
    localparam int TMR_W    = $clog2(WRITE_CYC + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic [PAGE_N-1:0][DATA_W-1:0]  pg_data,
    input  logic [PAGE_N-1:0]              pg_mask,
    input  logic [ROW_W-1:0]               pg_row,
    input  logic [DATA_W-1:0]              last_data,
    input  logic [ARR_W-1:0]               rd_addr,
    input  logic                           rd_end,
    output logic                           busy,
    output logic                           done,
    output logic [DATA_W-1:0]              dout
);

    logic [DATA_W-1:0] mem [ARR_N];
    logic [TMR_W-1:0]  tmr;
    logic              tog;

    // Internal write timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            tmr  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            tmr  <= TMR_W'(WRITE_CYC - 1);
        end else if (busy) begin
            if (tmr == '0) begin
                busy <= 1'b0;
            end else begin
                tmr <= tmr - 1'b1;
            end
        end
    end

    assign done = busy && (tmr == '0);

    // Array clear on reset and masked page commit at write end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ARR_N; i++) begin
                mem[i] <= '0;
            end
        end else if (done) begin
            for (int i = 0; i < PAGE_N; i++) begin
                if (pg_mask[i]) begin
                    mem[{pg_row, PAGE_W'(i)}] <= pg_data[i];
                end
            end
        end
    end

    // Toggle status flips at the end of each read while writing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog <= 1'b0;
        end else if (rd_end && busy) begin
            tog <= ~tog;
        end
    end

    // Read data: status word while writing, stored byte otherwise.
    always_comb begin
        if (busy) begin
            dout = {~last_data[7], tog ^ last_data[6], last_data[5:0]};
        end else begin
            dout = mem[rd_addr];
        end
    end

    AST_WRITE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R6
    AST_TOGGLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(tog)); // R8

endmodule

// File: rtl/eep_ctl.sv
// Top of the parallel EEPROM controller: strobe sampler, protection guard,
// page loader and timed storage. Drives the bus enable for read accesses only.
// Assumes ARR_W <= ADDR_W; addresses alias onto the array by their low bits.
module eep_ctl #(
    parameter int ADDR_W    = 13,
    parameter int DATA_W    = 8,
    parameter int PAGE_W    = 6,
    parameter int ARR_W     = 11,
    parameter int LOAD_WIN  = 100,
    parameter int WRITE_CYC = 500000,
    localparam int PAGE_N   = 1 << PAGE_W,
    localparam int ROW_W    = ARR_W - PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);

    logic              wr_end, rd_start, rd_end;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              take, busy, done, win_expire, start;
    logic [PAGE_N-1:0][DATA_W-1:0] pg_data;
    logic [PAGE_N-1:0] pg_mask;
    logic [ROW_W-1:0]  pg_row;
    logic [DATA_W-1:0] last_data;

    eep_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_strobe (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .wr_end(wr_end), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_start(rd_start), .rd_end(rd_end)
    );

    eep_guard #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_guard (
        .clk(clk), .rst_n(rst_n), .wr_end(wr_end), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_start(rd_start), .busy(busy),
        .win_expire(win_expire), .take(take)
    );

    eep_page #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W),
               .ARR_W(ARR_W), .LOAD_WIN(LOAD_WIN)) u_page (
        .clk(clk), .rst_n(rst_n), .take(take), .wr_end(wr_end),
        .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .done(done),
        .pg_data(pg_data), .pg_mask(pg_mask), .pg_row(pg_row),
        .last_data(last_data), .win_expire(win_expire), .start(start)
    );

    eep_array #(.DATA_W(DATA_W), .PAGE_W(PAGE_W), .ARR_W(ARR_W),
                .WRITE_CYC(WRITE_CYC)) u_array (
        .clk(clk), .rst_n(rst_n), .start(start), .pg_data(pg_data),
        .pg_mask(pg_mask), .pg_row(pg_row), .last_data(last_data),
        .rd_addr(addr[ARR_W-1:0]), .rd_end(rd_end), .busy(busy),
        .done(done), .dout(dout)
    );

    // Bus drive only for a read access.
    assign dout_oe = !ce_n && !oe_n && we_n;

    AST_START_HAS_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (pg_mask != '0)); // R4

endmodule

// File: tb/eep_ctl_tb.sv
module eep_ctl_tb;

    localparam int LW = 8;
    localparam int WC = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [12:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_oe;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    eep_ctl #(.LOAD_WIN(LW), .WRITE_CYC(WC)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [12:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic rd(input logic [12:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        @(posedge clk);
        #1;
        d = dout; oe = dout_oe;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic wait_done(input logic [12:0] a, input logic [7:0] exp, input string req);
        logic [7:0] d;
        logic oe;
        idle(LW + 2);
        for (int k = 0; k < 100; k++) begin
            rd(a, d, oe);
            if (d == exp) break;
        end
        chk(req, d, exp);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        logic oe;
        @(negedge clk);
        chk("R1 idle bus enable", {7'd0, dout_oe}, 8'h00);
        rd(13'h005, d, oe);
        chk("R1 reset content", d, 8'h00);
        chk("R1 read bus enable", {7'd0, oe}, 8'h01);
    endtask

    task automatic t_single();
        logic [7:0] d1, d2;
        logic oe;
        wr(13'h010, 8'h3C);
        idle(LW + 2);
        rd(13'h010, d1, oe);
        rd(13'h010, d2, oe);
        chk("R7 polled bit7 inverted", {7'd0, d1[7]}, 8'h01);
        chk("R8 bit6 toggles while writing", {7'd0, d1[6] ^ d2[6]}, 8'h01);
        wait_done(13'h010, 8'h3C, "R7 true data after write");
        rd(13'h010, d1, oe);
        rd(13'h010, d2, oe);
        chk("R8 bit6 steady after write", {7'd0, d1[6] ^ d2[6]}, 8'h00);
        chk("R4 single byte stored", d2, 8'h3C);
    endtask

    task automatic t_page();
        logic [7:0] d;
        logic oe;
        for (int i = 0; i < 64; i++) begin
            wr(13'h0C0 + 13'(i), 8'(i * 7 + 3));
            if (i == 20) wr(13'h100, 8'h77);
        end
        wait_done(13'h0FF, 8'(63 * 7 + 3), "R4 page write end");
        for (int i = 0; i < 64; i++) begin
            rd(13'h0C0 + 13'(i), d, oe);
            chk("R4 page byte", d, 8'(i * 7 + 3));
        end
        rd(13'h100, d, oe);
        chk("R5 other page byte dropped", d, 8'h00);
    endtask

    task automatic t_strobe();
        logic [7:0] d;
        logic oe;
        @(negedge clk);
        addr = 13'h070; din = 8'hA1; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        addr = 13'h071; din = 8'hB2;
        @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        wait_done(13'h070, 8'hB2, "R3 first address last data");
        rd(13'h071, d, oe);
        chk("R3 late address ignored", d, 8'h00);
        @(negedge clk);
        addr = 13'h020; din = 8'h5C; oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0;
        idle(2);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        idle(LW + WC + 10);
        rd(13'h020, d, oe);
        chk("R2 strobe with oe low stores nothing", d, 8'h00);
    endtask

    task automatic t_busy();
        logic [7:0] d;
        logic oe;
        wr(13'h030, 8'h11);
        idle(LW + 2);
        rd(13'h030, d, oe);
        chk("R6 window closed and write running", {7'd0, d[7]}, 8'h01);
        wr(13'h031, 8'h22);
        wait_done(13'h030, 8'h11, "R6 write completes");
        rd(13'h031, d, oe);
        chk("R6 byte during write dropped", d, 8'h00);
    endtask

    task automatic t_protect();
        logic [7:0] d;
        logic oe;
        wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'hA0);
        wr(13'h050, 8'h99);
        wait_done(13'h050, 8'h99, "R9 armed write stored");
        rd(13'h1555, d, oe);
        chk("R12 command byte not stored A", d, 8'h00);
        rd(13'h0AAA, d, oe);
        chk("R12 command byte not stored B", d, 8'h00);
        wr(13'h051, 8'h44);
        idle(LW + WC + 10);
        rd(13'h051, d, oe);
        chk("R9 plain write dropped when protected", d, 8'h00);
        wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'hA0);
        wr(13'h052, 8'h66);
        wait_done(13'h052, 8'h66, "R9 rearmed write stored");
    endtask

    task automatic t_abort();
        logic [7:0] d;
        logic oe;
        wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'h80);
        rd(13'h000, d, oe);
        wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'h20);
        wr(13'h060, 8'h12);
        idle(LW + WC + 10);
        rd(13'h060, d, oe);
        chk("R11 aborted unlock keeps protection", d, 8'h00);
        rd(13'h1555, d, oe);
        chk("R12 stray command data not stored", d, 8'h00);
    endtask

    task automatic t_unlock();
        wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'h80);
        wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'h20);
        wr(13'h061, 8'h34);
        wait_done(13'h061, 8'h34, "R10 plain write stored after unlock");
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_page();
        t_strobe();
        t_busy();
        t_protect();
        t_abort();
        t_unlock();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #500000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule